// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the PHY end of a two-wire serial management bus. It runs on the management clock, follows the data line bit by bit, and recognises read and write frames sent to its own 5-bit PHY address. On a read it takes over the data line through an output enable for the second turnaround bit and the sixteen data bits. On a write it updates the addressed register at the last data bit. Frames for other PHY addresses, frames with an unknown opcode, and frames with too short a preamble pass by without effect.

Behind the frame engine sits a 32-entry register space. The standard control, status, identifier, advertisement, partner-ability and expansion words come first. Addresses 7 to 15 are unimplemented. The vendor words sit in the upper half. Status comes in on plain wires and control goes out on plain wires. Two control bits clear themselves after one cycle: the negotiation restart and the software reset. The link bit in the status word latches low. One vendor field survives a software reset and is cleared only by the hardware reset pin.

Top module: `mdio_reg_slave`

## Requirements
- R1: A frame is accepted after at least PRE_LEN ones, start bits 0 then 1, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first. On a matching read the slave drives 0 in the second turnaround bit, then D15 down to D0, and releases the line after D0, so the line is driven for exactly 17 bit periods.
- R2: A frame whose PHY address differs from `phy_addr` never drives the line and changes no register.
- R3: Word 0 holds loopback (bit 14), speed 100 (bit 13), negotiation enable (bit 12), power down (bit 11), isolate (bit 10) and full duplex (bit 8). Each of these is writable and appears on its control output. All other bits read 0. The value after reset is 16'h3000.
- R4: Writing 1 to word 0 bit 9 gives a one-cycle pulse on `ctl_an_restart`, and bit 9 always reads 0.
- R5: Writing 1 to word 0 bit 15 returns words 0, 4 and 17 to their reset values one cycle after the write. Word 18 keeps its value, and bit 15 reads 0.
- R6: The hardware reset returns every register to its reset value, including word 18.
- R7: Word 1 reads {0, 1111, 00000, an_done, rem_fault, 1, link, 0, 1}. The link bit (bit 2) is cleared whenever `link_up` is low. It reports the current level only after it has been read once, and it reads 0 after reset.
- R8: Words 2 and 3 read the parameters ID_HI and ID_LO, and writes to them are ignored.
- R9: Word 4 reads {0000000, adv[3:0], 00001}. Bits 8:5 are writable with reset value 1111, so the reset value is 16'h01E1.
- R10: Word 5 reads `lp_ability`, word 6 reads 0, and writes to either are ignored.
- R11: Words 7 to 15 read 16'hFFFF whatever was written to them.
- R12: Word 17 reads {misc[7:0], 000000, energy_on, 0} with bits 15:8 writable. Word 18 reads {00000000, sticky[7:0]} with bits 7:0 writable. Word 31 reads an_done at bit 12 and the live `link_up` at bit 2. All other vendor words read 0.
- R13: Frames with opcode 00 or 11, and frames preceded by fewer than PRE_LEN ones, are ignored and never drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, data sampled on the rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| phy_addr | input | 5 | PHY address this slave answers to |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during a read reply |
| mdio_oe | output | 1 | Output enable for the data line |
| link_up | input | 1 | Live link status |
| an_done | input | 1 | Negotiation complete status |
| rem_fault | input | 1 | Remote fault status |
| energy_on | input | 1 | Line energy detected status |
| lp_ability | input | 16 | Link partner ability word |
| ctl_loopback | output | 1 | Loopback control |
| ctl_speed100 | output | 1 | Speed select, 1 for 100 Mb/s |
| ctl_an_enable | output | 1 | Negotiation enable |
| ctl_power_down | output | 1 | Power down control |
| ctl_isolate | output | 1 | Data path isolate control |
| ctl_full_duplex | output | 1 | Duplex select |
| ctl_an_restart | output | 1 | One-cycle negotiation restart pulse |
| ctl_adv | output | 4 | Advertised abilities |
| ctl_misc | output | 8 | Vendor control field, cleared by software reset |
| ctl_sticky | output | 8 | Vendor control field, cleared by hardware reset only |

## Verification
The bench builds the slave with the default 32-bit preamble and with distinctive identifier patterns, so that a wrong word on a read shows up at once. With only 32 register addresses and 32 PHY addresses, it can read every address before and after writing all ones to it. It also sends both a write and a read to every foreign PHY address and counts the bit periods in which the line is driven. This covers the read-only, reserved and all-ones words, the drive window of every reply, and the rejection of foreign frames. A separate sequence covers the self-clearing bits, the two reset scopes and the latched-low link bit.

// File: rtl/mdio_reg_slave.sv
module mdio_reg_slave #(
  parameter int          PRE_LEN = 32,
  parameter logic [15:0] ID_HI   = 16'h2C91,
  parameter logic [15:0] ID_LO   = 16'h7E03
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        rem_fault,
  input  logic        energy_on,
  input  logic [15:0] lp_ability,
  output logic        ctl_loopback,
  output logic        ctl_speed100,
  output logic        ctl_an_enable,
  output logic        ctl_power_down,
  output logic        ctl_isolate,
  output logic        ctl_full_duplex,
  output logic        ctl_an_restart,
  output logic [3:0]  ctl_adv,
  output logic [7:0]  ctl_misc,
  output logic [7:0]  ctl_sticky
);

  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] PRE_FULL = PW'(PRE_LEN);

  typedef enum logic [2:0] {S_PRE, S_ST, S_HDR, S_TA, S_DATA} st_t;

  st_t         st;
  logic [PW-1:0] ones;
  logic [3:0]  cnt;
  logic [10:0] hdr;
  logic [11:0] hdr_nxt;
  logic [4:0]  ra;
  logic        is_rd, is_wr;
  logic [15:0] rsh, wsh, wd, rd_val;
  logic        hit, rd_hit, wr_fire, sw_rst, link_lat;
  logic [1:0]  op_n;

  assign hdr_nxt = {hdr, mdio_i};
  assign op_n    = hdr_nxt[11:10];
  assign hit     = hdr_nxt[9:5] == phy_addr;
  assign rd_hit  = (st == S_HDR) && (cnt == 4'd11) && hit && (op_n == 2'b10);
  assign wd      = {wsh[14:0], mdio_i};
  assign wr_fire = (st == S_DATA) && (cnt == 4'd15) && is_wr;

  always_comb begin
    if (hdr_nxt[4:0] >= 5'd7 && hdr_nxt[4:0] <= 5'd15) rd_val = 16'hFFFF;
    else begin
      case (hdr_nxt[4:0])
        5'd0:  rd_val = {1'b0, ctl_loopback, ctl_speed100, ctl_an_enable, ctl_power_down,
                         ctl_isolate, 1'b0, ctl_full_duplex, 8'h00};
        5'd1:  rd_val = {1'b0, 4'hF, 5'b0, an_done, rem_fault, 1'b1, link_lat, 1'b0, 1'b1};
        5'd2:  rd_val = ID_HI;
        5'd3:  rd_val = ID_LO;
        5'd4:  rd_val = {7'b0, ctl_adv, 5'b00001};
        5'd5:  rd_val = lp_ability;
        5'd17: rd_val = {ctl_misc, 6'b0, energy_on, 1'b0};
        5'd18: rd_val = {8'h00, ctl_sticky};
        5'd31: rd_val = {3'b0, an_done, 9'b0, link_up, 2'b0};
        default: rd_val = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE; ones <= '0; cnt <= '0; hdr <= '0; ra <= '0;
      is_rd <= 1'b0; is_wr <= 1'b0; rsh <= '0; wsh <= '0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      case (st)
        S_PRE: begin
          if (mdio_i) begin
            if (ones != PRE_FULL) ones <= ones + 1'b1;
          end else begin
            if (ones == PRE_FULL) st <= S_ST;
            ones <= '0;
          end
        end
        S_ST: begin
          cnt <= '0;
          st  <= mdio_i ? S_HDR : S_PRE;
        end
        S_HDR: begin
          hdr <= hdr_nxt[10:0];
          cnt <= cnt + 1'b1;
          if (cnt == 4'd11) begin
            st    <= S_TA;
            cnt   <= '0;
            ra    <= hdr_nxt[4:0];
            is_rd <= rd_hit;
            is_wr <= hit && (op_n == 2'b01);
            rsh   <= rd_val;
          end
        end
        S_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == 4'd0) begin
            mdio_oe <= is_rd;
            mdio_o  <= 1'b0;
          end else begin
            st     <= S_DATA;
            cnt    <= '0;
            mdio_o <= rsh[15];
            rsh    <= {rsh[14:0], 1'b0};
          end
        end
        S_DATA: begin
          wsh    <= wd;
          cnt    <= cnt + 1'b1;
          mdio_o <= rsh[15];
          rsh    <= {rsh[14:0], 1'b0};
          if (cnt == 4'd15) begin
            st <= S_PRE; ones <= '0;
            mdio_oe <= 1'b0; mdio_o <= 1'b0;
            is_rd <= 1'b0; is_wr <= 1'b0;
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctl_loopback <= 1'b0; ctl_speed100 <= 1'b1; ctl_an_enable <= 1'b1;
      ctl_power_down <= 1'b0; ctl_isolate <= 1'b0; ctl_full_duplex <= 1'b0;
      ctl_an_restart <= 1'b0; sw_rst <= 1'b0; ctl_adv <= 4'hF; ctl_misc <= 8'h00;
    end else begin
      ctl_an_restart <= 1'b0;
      sw_rst         <= 1'b0;
      if (sw_rst) begin
        ctl_loopback <= 1'b0; ctl_speed100 <= 1'b1; ctl_an_enable <= 1'b1;
        ctl_power_down <= 1'b0; ctl_isolate <= 1'b0; ctl_full_duplex <= 1'b0;
        ctl_adv <= 4'hF; ctl_misc <= 8'h00;
      end else if (wr_fire) begin
        case (ra)
          5'd0: begin
            if (wd[15]) sw_rst <= 1'b1;
            else begin
              ctl_loopback    <= wd[14];
              ctl_speed100    <= wd[13];
              ctl_an_enable   <= wd[12];
              ctl_power_down  <= wd[11];
              ctl_isolate     <= wd[10];
              ctl_an_restart  <= wd[9];
              ctl_full_duplex <= wd[8];
            end
          end
          5'd4:  ctl_adv  <= wd[8:5];
          5'd17: ctl_misc <= wd[15:8];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) ctl_sticky <= 8'h00;
    else if (wr_fire && ra == 5'd18) ctl_sticky <= wd[7:0];
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) link_lat <= 1'b0;
    else if (!link_up) link_lat <= 1'b0;
    else if (rd_hit && hdr_nxt[4:0] == 5'd1) link_lat <= 1'b1;
  end

  AST_OE_IN_REPLY: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (is_rd && (st == S_TA || st == S_DATA))) else $error("oe outside reply"); // R1
  AST_TA_LOW: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o) else $error("turnaround not low"); // R1
  AST_FOREIGN_IGNORED: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == S_HDR && cnt == 4'd11 && !hit) |=> (!is_rd && !is_wr)) else $error("foreign frame taken"); // R2
  AST_RESTART_ONE: assert property (@(posedge mdc) disable iff (!rst_n)
    ctl_an_restart |=> !ctl_an_restart) else $error("restart not a pulse"); // R4
  AST_SWRST_DEF: assert property (@(posedge mdc) disable iff (!rst_n)
    sw_rst |=> (ctl_speed100 && ctl_an_enable && !ctl_isolate && !ctl_power_down &&
                !ctl_loopback && !ctl_full_duplex && ctl_adv == 4'hF && ctl_misc == 8'h00))
    else $error("soft reset incomplete"); // R5
  AST_LINK_DROP: assert property (@(posedge mdc) disable iff (!rst_n)
    !link_up |=> !link_lat) else $error("link latch kept"); // R7

endmodule

// File: tb/mdio_reg_slave_tb.sv
module mdio_reg_slave_tb;
  localparam logic [15:0] IDH = 16'hA5C3;
  localparam logic [15:0] IDL = 16'h5A3C;
  localparam logic [4:0]  MY  = 5'd13;
  localparam int          PRE = 32;

  logic mdc = 1'b0;
  always #10 mdc = ~mdc;

  logic rst_n = 1'b0;
  logic m_oe = 1'b0, m_bit = 1'b1;
  logic dut_o, dut_oe;
  logic link_up = 1'b1, an_done = 1'b1, rem_fault = 1'b0, energy_on = 1'b1;
  logic [15:0] lp_ability = 16'h45E1;
  logic c_lb, c_spd, c_ane, c_pd, c_iso, c_dup, c_rst;
  logic [3:0] c_adv;
  logic [7:0] c_misc, c_sticky;
  wire bus = dut_oe ? dut_o : (m_oe ? m_bit : 1'b1);

  mdio_reg_slave #(.PRE_LEN(PRE), .ID_HI(IDH), .ID_LO(IDL)) u_dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(MY), .mdio_i(bus), .mdio_o(dut_o), .mdio_oe(dut_oe),
    .link_up(link_up), .an_done(an_done), .rem_fault(rem_fault), .energy_on(energy_on),
    .lp_ability(lp_ability), .ctl_loopback(c_lb), .ctl_speed100(c_spd), .ctl_an_enable(c_ane),
    .ctl_power_down(c_pd), .ctl_isolate(c_iso), .ctl_full_duplex(c_dup), .ctl_an_restart(c_rst),
    .ctl_adv(c_adv), .ctl_misc(c_misc), .ctl_sticky(c_sticky));

  int checks = 0, fails = 0, drv = 0;
  always @(negedge mdc) if (dut_oe) drv++;

  logic [15:0] c0_m;
  logic [3:0]  adv_m;
  logic [7:0]  v17_m, v18_m;
  logic        lat_m;

  task automatic eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sdef();
    c0_m = 16'h3000; adv_m = 4'hF; v17_m = 8'h00;
  endtask

  function automatic logic [15:0] ctl_word();
    return {1'b0, c_lb, c_spd, c_ane, c_pd, c_iso, 1'b0, c_dup, 8'h00};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] r);
    if (r >= 5'd7 && r <= 5'd15) return 16'hFFFF;
    case (r)
      5'd0:  return c0_m;
      5'd1:  return {1'b0, 4'hF, 5'b0, an_done, rem_fault, 1'b1, lat_m, 1'b0, 1'b1};
      5'd2:  return IDH;
      5'd3:  return IDL;
      5'd4:  return {7'b0, adv_m, 5'b00001};
      5'd5:  return lp_ability;
      5'd17: return {v17_m, 6'b0, energy_on, 1'b0};
      5'd18: return {8'h00, v18_m};
      5'd31: return {3'b0, an_done, 9'b0, link_up, 2'b0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] r);
    if (r == 0) return "R3";
    if (r == 1) return "R7";
    if (r == 2 || r == 3) return "R8";
    if (r == 4) return "R9";
    if (r == 5 || r == 6) return "R10";
    if (r <= 15) return "R11";
    return "R12";
  endfunction

  task automatic tx(input logic b);
    @(negedge mdc); m_oe = 1'b1; m_bit = b;
  endtask

  task automatic frame(input logic [4:0] p, input logic [4:0] r, input logic [1:0] op,
                       input logic [15:0] w, input int pre,
                       output logic [15:0] d, output logic ta2, output int nd);
    int d0;
    d0 = drv; d = '0; ta2 = 1'b1;
    tx(1'b0);
    repeat (pre) tx(1'b1);
    tx(1'b0); tx(1'b1); tx(op[1]); tx(op[0]);
    for (int i = 4; i >= 0; i--) tx(p[i]);
    for (int i = 4; i >= 0; i--) tx(r[i]);
    if (op == 2'b10) begin
      @(negedge mdc); m_oe = 1'b0;
      @(negedge mdc); #2 ta2 = bus;
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc); #2 d[i] = bus;
      end
    end else begin
      tx(1'b1); tx(1'b0);
      for (int i = 15; i >= 0; i--) tx(w[i]);
    end
    @(negedge mdc); m_oe = 1'b0; #2 nd = drv - d0;
  endtask

  task automatic wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] w);
    logic [15:0] d; logic t; int nd;
    frame(p, r, 2'b01, w, PRE, d, t, nd);
    eq("R2 write never drives", 16'(nd), 16'd0);
    if (p == MY) begin
      case (r)
        5'd0:  if (w[15]) sdef(); else c0_m = w & 16'h7D00;
        5'd4:  adv_m = w[8:5];
        5'd17: v17_m = w[15:8];
        5'd18: v18_m = w[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [4:0] p, input logic [4:0] r);
    logic [15:0] d; logic t; int nd;
    frame(p, r, 2'b10, 16'h0, PRE, d, t, nd);
    if (p == MY) begin
      eq(tag_of(r), d, exp_rd(r));
      eq("R1 turnaround bit", {15'b0, t}, 16'd0);
      eq("R1 drive window", 16'(nd), 16'd17);
      if (r == 5'd1) lat_m = link_up;
    end else begin
      eq("R2 foreign read drive", 16'(nd), 16'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d; logic t; int nd;
    sdef(); v18_m = 8'h00; lat_m = 1'b0;
    repeat (3) @(negedge mdc);
    eq("R3 reset control word", ctl_word(), 16'h3000);
    eq("R9 reset adv", {12'b0, c_adv}, 16'h000F);
    eq("R6 reset vendor fields", {c_misc, c_sticky}, 16'h0000);
    eq("R1 reset no drive", {15'b0, dut_oe}, 16'd0);
    rst_n = 1'b1;
    @(negedge mdc);

    for (int r = 0; r < 32; r++) rd(MY, 5'(r));
    rd(MY, 5'd1);
    for (int r = 1; r < 32; r++) wr(MY, 5'(r), 16'hFFFF);
    for (int r = 0; r < 32; r++) rd(MY, 5'(r));

    wr(MY, 5'd0, 16'h7D00);
    eq("R3 control outputs", ctl_word(), 16'h7D00);
    rd(MY, 5'd0);
    wr(MY, 5'd0, 16'h0200);
    eq("R4 restart pulse high", {15'b0, c_rst}, 16'd1);
    @(negedge mdc); #2;
    eq("R4 restart pulse cleared", {15'b0, c_rst}, 16'd0);
    rd(MY, 5'd0);

    wr(MY, 5'd0, 16'h7D00);
    wr(MY, 5'd4, 16'h0000);
    wr(MY, 5'd17, 16'hAB00);
    wr(MY, 5'd18, 16'h005A);
    eq("R12 vendor outputs", {c_misc, c_sticky}, 16'hAB5A);
    wr(MY, 5'd0, 16'h8000);
    @(negedge mdc); #2;
    eq("R5 soft reset control", ctl_word(), 16'h3000);
    eq("R5 sticky kept", {8'h00, c_sticky}, 16'h005A);
    rd(MY, 5'd0); rd(MY, 5'd4); rd(MY, 5'd17); rd(MY, 5'd18);

    link_up = 1'b0; lat_m = 1'b0;
    repeat (3) @(negedge mdc);
    link_up = 1'b1;
    rd(MY, 5'd31);
    rd(MY, 5'd1);
    rd(MY, 5'd1);

    frame(MY, 5'd4, 2'b00, 16'hFFFF, PRE, d, t, nd);
    eq("R13 opcode 00 no drive", 16'(nd), 16'd0);
    frame(MY, 5'd4, 2'b11, 16'hFFFF, PRE, d, t, nd);
    eq("R13 opcode 11 no drive", 16'(nd), 16'd0);
    frame(MY, 5'd4, 2'b01, 16'hFFFF, PRE - 12, d, t, nd);
    frame(MY, 5'd4, 2'b10, 16'h0, PRE - 12, d, t, nd);
    eq("R13 short preamble no drive", 16'(nd), 16'd0);
    rd(MY, 5'd4);

    for (int p = 0; p < 32; p++) begin
      if (5'(p) != MY) begin
        wr(5'(p), 5'd17, 16'h5500);
        rd(5'(p), 5'd0);
      end
    end
    rd(MY, 5'd17);
    eq("R2 foreign writes ignored", {c_misc, 8'h00}, 16'h0000);

    rst_n = 1'b0;
    @(negedge mdc);
    rst_n = 1'b1;
    sdef(); v18_m = 8'h00; lat_m = 1'b0;
    @(negedge mdc);
    eq("R6 hardware reset sticky", {8'h00, c_sticky}, 16'h0000);
    rd(MY, 5'd18);
    rd(MY, 5'd0);
    rd(MY, 5'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule